// File: doc/BRIEF.md
# Integer Compare Unit with Mask Result

This block is the integer compare stage of a compact load/store processor core. Each cycle it may accept one compare: two 32-bit operands, a 4-bit condition code and a mode bit. It checks the chosen signed or unsigned relation and returns a full-width mask through a single register write port. The mask is all ones when the relation holds and all zeros when it does not. The result, its valid strobe and the write enable appear one clock after the request.

The block has two modes. In short mode it serves a dense 16-bit instruction encoding:

- both operands come from registers;
- only six relations are available;
- the mask always goes to register zero.

In wide mode it serves a 32-bit encoding:

- four more relations are available;
- the second operand may be a 16-bit immediate;
- the destination is any general register.

In wide mode register zero is a hardwired zero, so a compare aimed at it produces no write. Register file reads, forwarding and branching are handled outside this block.

Top module: `cmp_mask_unit`

## Requirements
- R1: When a legal compare is accepted, `wr_data` one cycle later is all ones if the relation holds and all zeros otherwise.
- R2: In short mode (`wide_mode`=0), a legal compare writes to index 0 whatever value `dest_idx` carries.
- R3: In short mode, `use_imm` and `imm` have no effect and `src_b` is always the second operand.
- R4: In short mode, the legal condition codes are 0 eq, 1 neq, 2 lt (signed), 3 ltu, 4 le (signed) and 5 leu. "less" compares `src_a` against the second operand.
- R5: In short mode, codes 6 to 15 are illegal. One cycle later `illegal`=1, `wr_en`=0, `wr_idx`=0 and `wr_data`=0.
- R6: In wide mode, codes 6 gt (signed), 7 gtu, 8 ge (signed) and 9 geu are added to codes 0 to 5. Codes 10 to 15 are illegal, with the same outputs as in R5.
- R7: In wide mode with `use_imm`=1, the second operand is `imm`. It is sign-extended for codes 0, 1, 2, 4, 6 and 8, and zero-extended for codes 3, 5, 7 and 9.
- R8: In wide mode, a legal compare targets `dest_idx` with `wr_en`=1. When `dest_idx` is 0, `wr_en` is 0 while `out_valid` and `wr_data` still report the result and `illegal` stays 0.
- R9: `out_valid` equals `in_valid` of the previous cycle. When `out_valid` is 0, the outputs `wr_en`, `illegal`, `wr_idx` and `wr_data` are all 0.
- R10: While `rst` is high and in the cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A compare request is present this cycle |
| wide_mode | input | 1 | 1 selects the wide-encoding variant |
| cond_code | input | 4 | Relation to evaluate |
| src_a | input | 32 | Left operand |
| src_b | input | 32 | Right register operand |
| use_imm | input | 1 | Wide mode: take the right operand from `imm` |
| imm | input | 16 | Immediate right operand |
| dest_idx | input | 5 | Wide-mode destination register |
| out_valid | output | 1 | Result of last cycle's request is present |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 5 | Register write index |
| wr_data | output | 32 | All-ones or all-zeros mask |
| illegal | output | 1 | Last cycle's request carried an unsupported code |

## Verification
Directed pairs target each relation on both sides of its boundary. These include equal operands, where the le, lt, ge and gt pairs must split. They also include a negative value set against a positive one, where the signed and unsigned forms of the same relation must disagree. Immediate values of 0xFFFF and 0x8000 separate sign extension from zero extension. Short-mode requests carry an immediate and a non-zero destination that would change the result if either were wrongly honoured. Every code from 6 to 15 is sent in short mode and every code from 10 to 15 in wide mode. Idle gaps and a long run of random requests, some with equal operands, check the one-cycle alignment of valid, enable and data.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int COND_W = 4;

    typedef enum logic [COND_W-1:0] {
        C_EQ  = 4'd0,
        C_NE  = 4'd1,
        C_LT  = 4'd2,
        C_LTU = 4'd3,
        C_LE  = 4'd4,
        C_LEU = 4'd5,
        C_GT  = 4'd6,
        C_GTU = 4'd7,
        C_GE  = 4'd8,
        C_GEU = 4'd9
    } cond_e;

    localparam cond_e SHORT_LAST = C_LEU;
    localparam cond_e WIDE_LAST  = C_GEU;

    typedef enum logic [2:0] {
        REL_EQ,
        REL_NE,
        REL_LT,
        REL_LE,
        REL_GT,
        REL_GE
    } rel_kind_e;

    typedef struct packed {
        logic      legal;
        logic      unsigned_rel;
        rel_kind_e kind;
    } cond_info_t;

    function automatic logic cond_is_unsigned(input cond_e c);
        return (c == C_LTU) || (c == C_LEU) || (c == C_GTU) || (c == C_GEU);
    endfunction

    function automatic logic cond_in_range(input logic [COND_W-1:0] c, input logic wide);
        return wide ? (c <= WIDE_LAST) : (c <= SHORT_LAST);
    endfunction

endpackage

// File: rtl/cmp_cond_decode.sv
module cmp_cond_decode
    import cmp_pkg::*;
(
    input  logic [COND_W-1:0] cond_code,
    input  logic              wide_mode,
    output cond_info_t        info
);

    always_comb begin
        info.legal        = cond_in_range(cond_code, wide_mode);
        info.unsigned_rel = cond_is_unsigned(cond_e'(cond_code));
        case (cond_e'(cond_code))
            C_EQ:          info.kind = REL_EQ;
            C_NE:          info.kind = REL_NE;
            C_LT, C_LTU:   info.kind = REL_LT;
            C_LE, C_LEU:   info.kind = REL_LE;
            C_GT, C_GTU:   info.kind = REL_GT;
            C_GE, C_GEU:   info.kind = REL_GE;
            default:       info.kind = REL_EQ;
        endcase
    end

endmodule

// File: rtl/cmp_operand_sel.sv
module cmp_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              wide_mode,
    input  logic              use_imm,
    input  logic              unsigned_rel,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] operand
);

    logic [DATA_W-1:0] imm_ext;

    generate
        if (DATA_W > IMM_W) begin : g_extend
            localparam int PAD_W = DATA_W - IMM_W;
            logic fill_bit;
            assign fill_bit = unsigned_rel ? 1'b0 : imm[IMM_W-1];
            assign imm_ext  = {{PAD_W{fill_bit}}, imm};
        end else begin : g_truncate
            logic unused_sel;
            assign unused_sel = unsigned_rel;
            assign imm_ext    = imm[DATA_W-1:0];
        end
    endgenerate

    assign operand = (wide_mode && use_imm) ? imm_ext : src_b;

endmodule

// File: rtl/cmp_relation_eval.sv
module cmp_relation_eval
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              unsigned_rel,
    input  rel_kind_e         kind,
    output logic              hit
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] lhs_x;
    logic [EXT_W-1:0] rhs_x;
    logic             less;
    logic             same;

    assign lhs_x = {~unsigned_rel & lhs[DATA_W-1], lhs};
    assign rhs_x = {~unsigned_rel & rhs[DATA_W-1], rhs};
    assign less  = $signed(lhs_x) < $signed(rhs_x);
    assign same  = (lhs == rhs);

    always_comb begin
        case (kind)
            REL_EQ:  hit = same;
            REL_NE:  hit = ~same;
            REL_LT:  hit = less;
            REL_LE:  hit = less | same;
            REL_GT:  hit = ~(less | same);
            REL_GE:  hit = ~less;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmp_mask_unit.sv
module cmp_mask_unit
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              wide_mode,
    input  logic [COND_W-1:0] cond_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic              out_valid,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              illegal
);

    cond_info_t        info;
    logic [DATA_W-1:0] rhs;
    logic              hit;
    logic              dest_is_zero;

    cmp_cond_decode u_decode (
        .cond_code (cond_code),
        .wide_mode (wide_mode),
        .info      (info)
    );

    cmp_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .wide_mode    (wide_mode),
        .use_imm      (use_imm),
        .unsigned_rel (info.unsigned_rel),
        .src_b        (src_b),
        .imm          (imm),
        .operand      (rhs)
    );

    cmp_relation_eval #(.DATA_W(DATA_W)) u_eval (
        .lhs          (src_a),
        .rhs          (rhs),
        .unsigned_rel (info.unsigned_rel),
        .kind         (info.kind),
        .hit          (hit)
    );

    assign dest_is_zero = (dest_idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && info.legal) begin
                wr_en   <= ~(wide_mode & dest_is_zero);
                wr_idx  <= wide_mode ? dest_idx : '0;
                wr_data <= {DATA_W{hit}};
                illegal <= 1'b0;
            end else begin
                wr_en   <= 1'b0;
                wr_idx  <= '0;
                wr_data <= '0;
                illegal <= in_valid;
            end
        end
    end

    // R1: result is always a full mask
    a_r1_full_mask: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (wr_data == '0 || wr_data == '1));

    // R2: short-mode writes land on index 0
    a_r2_short_to_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(wide_mode)) |-> (wr_idx == '0));

    // R5/R6: an illegal code never writes
    a_r5_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wr_en && wr_data == '0));

    // R8: wide-mode target of register zero is dropped
    a_r8_zero_dest_dropped: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_mode && dest_idx == '0) |=> !wr_en);

    // R9: one-cycle alignment of valid
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wr_en && !illegal && wr_data == '0));

endmodule

// File: tb/sim_cmp_mask_unit.sv
`timescale 1ns/1ps
module sim_cmp_mask_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        wide_mode = 1'b0;
    logic [3:0]  cond_code = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        use_imm = 1'b0;
    logic [15:0] imm = '0;
    logic [4:0]  dest_idx = '0;
    logic        out_valid;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic        illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic        pend = 1'b0;
    string       pend_tag;
    logic        e_valid, e_en, e_ill;
    logic [4:0]  e_idx;
    logic [31:0] e_data;

    always #2 clk = ~clk;

    cmp_mask_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
        .cond_code(cond_code), .src_a(src_a), .src_b(src_b), .use_imm(use_imm),
        .imm(imm), .dest_idx(dest_idx), .out_valid(out_valid), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .illegal(illegal)
    );

    task automatic compare(input string tag, input logic v, input logic en,
                           input logic [4:0] idx, input logic [31:0] data, input logic ill);
        n_checks++;
        if (out_valid !== v || wr_en !== en || wr_idx !== idx || wr_data !== data || illegal !== ill) begin
            n_fails++;
            $display("FAIL %s: got v=%b en=%b idx=%0d data=%h ill=%b, expected v=%b en=%b idx=%0d data=%h ill=%b",
                     tag, out_valid, wr_en, wr_idx, wr_data, illegal, v, en, idx, data, ill);
        end
    endtask

    task automatic apply(input string tag, input logic v, input logic w, input logic [3:0] c,
                         input logic [31:0] a, input logic [31:0] b, input logic ui,
                         input logic [15:0] im, input logic [4:0] d);
        logic legal, uns, rel;
        logic [31:0] opb;
        @(negedge clk);
        if (pend) compare(pend_tag, e_valid, e_en, e_idx, e_data, e_ill);
        in_valid = v; wide_mode = w; cond_code = c; src_a = a; src_b = b;
        use_imm = ui; imm = im; dest_idx = d;
        legal = w ? (c <= 4'd9) : (c <= 4'd5);
        uns = (c == 4'd3) || (c == 4'd5) || (c == 4'd7) || (c == 4'd9);
        if (w && ui) opb = uns ? {16'h0, im} : {{16{im[15]}}, im};
        else         opb = b;
        case (c)
            4'd0: rel = (a == opb);
            4'd1: rel = (a != opb);
            4'd2: rel = ($signed(a) <  $signed(opb));
            4'd3: rel = (a <  opb);
            4'd4: rel = ($signed(a) <= $signed(opb));
            4'd5: rel = (a <= opb);
            4'd6: rel = ($signed(a) >  $signed(opb));
            4'd7: rel = (a >  opb);
            4'd8: rel = ($signed(a) >= $signed(opb));
            4'd9: rel = (a >= opb);
            default: rel = 1'b0;
        endcase
        e_valid = v;
        e_ill   = v && !legal;
        e_en    = v && legal && (!w || d != 5'd0);
        e_idx   = (v && legal && w) ? d : 5'd0;
        e_data  = (v && legal && rel) ? 32'hFFFF_FFFF : 32'h0;
        pend_tag = tag;
        pend = 1'b1;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R10 in reset", 1'b0, 1'b0, 5'd0, 32'h0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        compare("R10 after reset", 1'b0, 1'b0, 5'd0, 32'h0, 1'b0);

        // short mode, six relations
        apply("R4 eq equal",      1, 0, 4'd0, 32'd5, 32'd5, 0, 16'h0, 5'd0);
        apply("R4 eq differ",     1, 0, 4'd0, 32'd5, 32'd6, 0, 16'h0, 5'd0);
        apply("R4 neq",           1, 0, 4'd1, 32'd5, 32'd6, 0, 16'h0, 5'd0);
        apply("R4 lt signed",     1, 0, 4'd2, 32'hFFFF_FFFF, 32'd1, 0, 16'h0, 5'd0);
        apply("R4 ltu",           1, 0, 4'd3, 32'hFFFF_FFFF, 32'd1, 0, 16'h0, 5'd0);
        apply("R4 le equal",      1, 0, 4'd4, 32'h8000_0000, 32'h8000_0000, 0, 16'h0, 5'd0);
        apply("R4 lt equal",      1, 0, 4'd2, 32'h8000_0000, 32'h8000_0000, 0, 16'h0, 5'd0);
        apply("R4 leu",           1, 0, 4'd5, 32'd7, 32'h8000_0000, 0, 16'h0, 5'd0);
        apply("R1 mask false",    1, 0, 4'd5, 32'h8000_0000, 32'd7, 0, 16'h0, 5'd0);
        // short ignores immediate and destination
        apply("R2 dest ignored",  1, 0, 4'd2, 32'd3, 32'd100, 0, 16'h0, 5'd7);
        apply("R3 imm ignored",   1, 0, 4'd2, 32'd3, 32'd100, 1, 16'd1, 5'd7);
        apply("R3 imm ignored eq",1, 0, 4'd0, 32'd9, 32'd9, 1, 16'd2, 5'd3);
        for (int c = 6; c < 16; c++)
            apply("R5 short illegal", 1, 0, 4'(c), 32'd1, 32'd1, 0, 16'h0, 5'd4);
        apply("R9 idle",          0, 0, 4'd0, 32'd1, 32'd1, 0, 16'h0, 5'd0);
        apply("R9 idle2",         0, 1, 4'd9, 32'd1, 32'd1, 0, 16'h0, 5'd3);
        // wide relations
        apply("R6 gt signed",     1, 1, 4'd6, 32'd1, 32'hFFFF_FFFF, 0, 16'h0, 5'd2);
        apply("R6 gtu",           1, 1, 4'd7, 32'd1, 32'hFFFF_FFFF, 0, 16'h0, 5'd2);
        apply("R6 ge equal",      1, 1, 4'd8, 32'd4, 32'd4, 0, 16'h0, 5'd2);
        apply("R6 gt equal",      1, 1, 4'd6, 32'd4, 32'd4, 0, 16'h0, 5'd2);
        apply("R6 geu",           1, 1, 4'd9, 32'h8000_0000, 32'd4, 0, 16'h0, 5'd31);
        for (int c = 10; c < 16; c++)
            apply("R6 wide illegal", 1, 1, 4'(c), 32'd1, 32'd1, 0, 16'h0, 5'd4);
        // wide immediates
        apply("R7 lt sext",       1, 1, 4'd2, 32'd0, 32'd0, 1, 16'hFFFF, 5'd5);
        apply("R7 ltu zext",      1, 1, 4'd3, 32'd0, 32'd0, 1, 16'hFFFF, 5'd5);
        apply("R7 eq sext",       1, 1, 4'd0, 32'hFFFF_8000, 32'd0, 1, 16'h8000, 5'd5);
        apply("R7 geu zext",      1, 1, 4'd9, 32'h0000_8000, 32'd0, 1, 16'h8000, 5'd5);
        apply("R7 gt sext",       1, 1, 4'd6, 32'd0, 32'd99, 1, 16'h8000, 5'd5);
        // wide destinations
        apply("R8 dest 0 dropped",1, 1, 4'd0, 32'd1, 32'd1, 0, 16'h0, 5'd0);
        apply("R8 dest 9",        1, 1, 4'd0, 32'd1, 32'd1, 0, 16'h0, 5'd9);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = ($urandom % 4 == 0) ? ra : $urandom;
            apply("R1 random", 1'($urandom % 5 != 0), 1'($urandom), 4'($urandom),
                  ra, rb, 1'($urandom), 16'($urandom), 5'($urandom));
        end
        apply("R9 flush",         0, 0, 4'd0, 32'd0, 32'd0, 0, 16'h0, 5'd0);
        @(negedge clk);
        compare(pend_tag, e_valid, e_en, e_idx, e_data, e_ill);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule